// File: doc/BRIEF.md
# Byte-Parity Protected RAM

This block wraps a word-wide synchronous RAM and stores one even-parity bit beside every byte, so a 32-bit word occupies 36 storage bits. Writes carry byte strobes. A byte, halfword or word store updates only the strobed bytes and their parity bits. A read returns its word one cycle after the request, with no wait states. In the same cycle the block checks the parity of every byte the read selected.

When checking is switched on and any selected byte fails, the read data goes out together with a bus error. The same cycle carries a one-cycle NMI request, so the faulty data is never taken as good. The failure also sets a sticky error flag, which software clears by writing 1. A lock bit, once set, routes every later failure to a break output meant for timer break inputs. An injection mask inverts stored parity on selected lanes, so a fault can be planted on purpose.

Top module: `bytepar_ram`

## Requirements
- R1: After reset, rvalid, bus_err, nmi_req, brk_out, err_flag and lock_q are all low.
- R2: A read request (req=1, we=0) sampled on a rising edge gives rvalid=1 and the stored word on rdata during the following cycle. rvalid is high only in that cycle.
- R3: On a write (req=1, we=1), be[i]=1 replaces wdata bits 8i+7..8i at addr; every byte with be[i]=0 keeps its old value.
- R4: Each written byte gets an even-parity bit: the XOR of the byte, inverted when inj_par[i]=1. Rewriting a byte with inj_par[i]=0 removes a planted fault.
- R5: During the rvalid cycle, bus_err and nmi_req are high exactly when checking was enabled at the request and some lane with be[i]=1 at the request fails parity. Lanes with be[i]=0 are never checked.
- R6: A read requested while par_en=0 never raises bus_err, nmi_req or brk_out.
- R7: err_flag goes high on the edge that ends a bus_err cycle and stays high until an err_clr pulse. A new error in the same cycle as err_clr keeps the flag set.
- R8: A lock_set pulse sets lock_q, which stays high until reset. brk_out is high exactly in bus_err cycles while lock_q is high.
- R9: nmi_req lasts one cycle for each failing read and is low when no read result is out.
- R10: A write never produces rvalid, bus_err or nmi_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_en | input | 1 | Enables parity checking for the read requested in this cycle |
| lock_set | input | 1 | Pulse that sets the break routing lock |
| err_clr | input | 1 | Write-1 clear of the sticky error flag |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| be | input | NL | Byte strobes, bit i selects bits 8i+7..8i |
| wdata | input | DW | Write data |
| inj_par | input | NL | Per-lane parity inversion applied on write |
| rdata | output | DW | Read data |
| rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Error response for the current read data |
| nmi_req | output | 1 | One-cycle NMI request on a parity failure |
| brk_out | output | 1 | Parity failure routed to break while locked |
| err_flag | output | 1 | Sticky parity error flag |
| lock_q | output | 1 | State of the break routing lock |

## Verification
A wrong parity bit in storage does not show on a write. It shows only on the first read of that word that selects the damaged lane with checking enabled, where bus_err and nmi_req rise in the same cycle as rdata. err_flag follows one edge later. A stale lane mask or enable is caught by reads that skip the corrupted lane or have checking off, which must stay silent. A lost lock shows as a missing brk_out on the next failing read.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
   localparam int unsigned LANE_W = 8;

   // even parity bit for one byte lane
   function automatic logic lane_par(input logic [LANE_W-1:0] b);
      return ^b;
   endfunction
endpackage

// File: rtl/bpr_encode.sv
module bpr_encode #(
   parameter int unsigned NL = 4,
   localparam int unsigned DW = NL * bpr_pkg::LANE_W
) (
   input  logic [DW-1:0] data_i,
   input  logic [NL-1:0] inj_i,
   output logic [NL-1:0] par_o
);
   for (genvar i = 0; i < NL; i++) begin : g_lane
      assign par_o[i] = bpr_pkg::lane_par(data_i[i*bpr_pkg::LANE_W +: bpr_pkg::LANE_W]) ^ inj_i[i];
   end
endmodule

// File: rtl/bpr_array.sv
module bpr_array #(
   parameter int unsigned NL    = 4,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned LW   = bpr_pkg::LANE_W,
   localparam int unsigned DW   = NL * LW,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_i,
   input  logic          rd_i,
   input  logic [AW-1:0] addr_i,
   input  logic [NL-1:0] be_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [NL-1:0] wpar_i,
   output logic [DW-1:0] rdata_o,
   output logic [NL-1:0] rpar_o
);
   // one 9-bit wide bank per lane; the lane strobe gates the write
   for (genvar i = 0; i < NL; i++) begin : g_bank
      logic [LW:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_i && be_i[i]) begin
            mem[addr_i] <= {wpar_i[i], wdata_i[i*LW +: LW]};
         end
         if (rd_i) begin
            {rpar_o[i], rdata_o[i*LW +: LW]} <= mem[addr_i];
         end
      end
   end
endmodule

// File: rtl/bpr_check.sv
module bpr_check #(
   parameter int unsigned NL = 4,
   localparam int unsigned DW = NL * bpr_pkg::LANE_W
) (
   input  logic [DW-1:0] data_i,
   input  logic [NL-1:0] par_i,
   input  logic [NL-1:0] lanes_i,
   input  logic          en_i,
   output logic          fail_o
);
   logic [NL-1:0] lane_bad;
   for (genvar i = 0; i < NL; i++) begin : g_lane
      assign lane_bad[i] = lanes_i[i] &&
         (bpr_pkg::lane_par(data_i[i*bpr_pkg::LANE_W +: bpr_pkg::LANE_W]) != par_i[i]);
   end
   assign fail_o = en_i && (|lane_bad);
endmodule

// File: rtl/bpr_status.sv
module bpr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_i,
   input  logic clr_i,
   input  logic lock_set_i,
   output logic flag_o,
   output logic lock_o,
   output logic brk_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         lock_o <= 1'b0;
      end else begin
         // a fresh failure outranks the clear
         if (fail_i)     flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
         if (lock_set_i) lock_o <= 1'b1;
      end
   end
   assign brk_o = fail_i && lock_o;
endmodule

// File: rtl/bytepar_ram.sv
module bytepar_ram #(
   parameter int unsigned NL    = 4,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned DW   = NL * bpr_pkg::LANE_W,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          par_en,
   input  logic          lock_set,
   input  logic          err_clr,
   input  logic          req,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [NL-1:0] be,
   input  logic [DW-1:0] wdata,
   input  logic [NL-1:0] inj_par,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic          bus_err,
   output logic          nmi_req,
   output logic          brk_out,
   output logic          err_flag,
   output logic          lock_q
);
   if (NL < 1) begin : g_bad_nl
      $error("bytepar_ram: NL must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("bytepar_ram: DEPTH must be at least 2");
   end

   logic          wr, rd;
   logic [NL-1:0] wpar, rpar;
   logic [NL-1:0] lanes_q;
   logic          chk_q;
   logic          fail;

   assign wr = req && we;
   assign rd = req && !we;

   bpr_encode #(.NL(NL)) u_enc (
      .data_i (wdata),
      .inj_i  (inj_par),
      .par_o  (wpar)
   );

   bpr_array #(.NL(NL), .DEPTH(DEPTH)) u_arr (
      .clk     (clk),
      .wr_i    (wr),
      .rd_i    (rd),
      .addr_i  (addr),
      .be_i    (be),
      .wdata_i (wdata),
      .wpar_i  (wpar),
      .rdata_o (rdata),
      .rpar_o  (rpar)
   );

   // request attributes travel alongside the read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid  <= 1'b0;
         lanes_q <= '0;
         chk_q   <= 1'b0;
      end else begin
         rvalid  <= rd;
         lanes_q <= rd ? be : '0;
         chk_q   <= rd && par_en;
      end
   end

   bpr_check #(.NL(NL)) u_chk (
      .data_i  (rdata),
      .par_i   (rpar),
      .lanes_i (lanes_q),
      .en_i    (chk_q && rvalid),
      .fail_o  (fail)
   );

   bpr_status u_sts (
      .clk        (clk),
      .rst_n      (rst_n),
      .fail_i     (fail),
      .clr_i      (err_clr),
      .lock_set_i (lock_set),
      .flag_o     (err_flag),
      .lock_o     (lock_q),
      .brk_o      (brk_out)
   );

   assign bus_err = fail;
   assign nmi_req = fail;
endmodule

// File: rtl/bpr_props.sv
module bpr_props (
   input logic clk,
   input logic rst_n,
   input logic par_en,
   input logic lock_set,
   input logic err_clr,
   input logic req,
   input logic we,
   input logic rvalid,
   input logic bus_err,
   input logic nmi_req,
   input logic brk_out,
   input logic err_flag,
   input logic lock_q
);
   a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we) |=> rvalid);
   a_r10_no_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we) |=> !rvalid);
   a_r5_err_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> rvalid);
   a_r6_off_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && !par_en) |=> !bus_err);
   a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> err_flag);
   a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);
   a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   a_r8_lock_takes: assert property (@(posedge clk) disable iff (!rst_n)
      lock_set |=> lock_q);
   a_r8_brk_gated: assert property (@(posedge clk) disable iff (!rst_n)
      brk_out |-> (bus_err && lock_q));
   a_r9_nmi_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> rvalid);
endmodule

bind bytepar_ram bpr_props u_props (
   .clk      (clk),
   .rst_n    (rst_n),
   .par_en   (par_en),
   .lock_set (lock_set),
   .err_clr  (err_clr),
   .req      (req),
   .we       (we),
   .rvalid   (rvalid),
   .bus_err  (bus_err),
   .nmi_req  (nmi_req),
   .brk_out  (brk_out),
   .err_flag (err_flag),
   .lock_q   (lock_q)
);

// File: tb/sim_bytepar_ram.sv
`timescale 1ns/1ps
module sim_bytepar_ram;
   localparam int NL = 4;
   localparam int DEPTH = 64;
   localparam int DW = 32;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic par_en = 1'b1, lock_set = 1'b0, err_clr = 1'b0;
   logic req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NL-1:0] be = '0, inj_par = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic rvalid, bus_err, nmi_req, brk_out, err_flag, lock_q;

   always #10 clk = ~clk;

   bytepar_ram #(.NL(NL), .DEPTH(DEPTH)) u0 (.*);

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] sh_data [DEPTH];
   logic [NL-1:0] sh_bad  [DEPTH];
   bit exp_lock = 1'b0;

   typedef struct { logic [DW-1:0] data; bit err; bit brk; string tag; } exp_t;
   exp_t q[$];

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d, input logic [NL-1:0] b,
                     input logic [NL-1:0] inj);
      req = 1; we = 1; addr = AW'(a); wdata = d; be = b; inj_par = inj;
      for (int i = 0; i < NL; i++) if (b[i]) begin
         sh_data[a][i*8 +: 8] = d[i*8 +: 8];
         sh_bad[a][i] = inj[i];
      end
      @(negedge clk);
      req = 0; we = 0; inj_par = '0;
   endtask

   task automatic rd(input int a, input logic [NL-1:0] b, input string tag);
      exp_t e;
      req = 1; we = 0; addr = AW'(a); be = b;
      e.data = sh_data[a];
      e.err  = par_en && ((b & sh_bad[a]) != '0);
      e.brk  = e.err && exp_lock;
      e.tag  = tag;
      q.push_back(e);
      @(negedge clk);
      req = 0;
   endtask

   // monitor: every result cycle is compared against the queue head
   always @(negedge clk) begin
      if (rst_n) begin
         if (rvalid) begin
            if (q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R10 actual rvalid=1 expected 0");
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({e.tag, " R2 rdata"}, rdata, e.data);
               chk({e.tag, " R5 bus_err"}, DW'(bus_err), DW'(e.err));
               chk({e.tag, " R9 nmi_req"}, DW'(nmi_req), DW'(e.err));
               chk({e.tag, " R8 brk_out"}, DW'(brk_out), DW'(e.brk));
            end
         end else begin
            if (bus_err || nmi_req || brk_out) begin
               checks++; errors++;
               $display("FAIL R9 actual err/nmi/brk=%b%b%b expected 000", bus_err, nmi_req, brk_out);
            end
         end
      end
   end

   initial begin
      #(20ns * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin sh_data[i] = '0; sh_bad[i] = '0; end
      idle(3);
      rst_n = 1;
      idle(1);
      // R1 reset state
      chk("R1 rvalid", DW'(rvalid), 0);
      chk("R1 bus_err", DW'(bus_err), 0);
      chk("R1 err_flag", DW'(err_flag), 0);
      chk("R1 lock_q", DW'(lock_q), 0);
      chk("R1 brk_out", DW'(brk_out), 0);

      // initialise the words used below
      for (int a = 0; a < 6; a++) wr(a, 32'h0, 4'hF, 4'h0);

      // R2 word access
      wr(0, 32'hA5A5_0F0F, 4'hF, 4'h0);
      rd(0, 4'hF, "word");
      idle(1);
      // R3 byte write keeps other lanes
      wr(1, 32'h1234_5678, 4'hF, 4'h0);
      wr(1, 32'h00CC_0000, 4'h4, 4'h0);
      rd(1, 4'hF, "R3 byte");
      // R3 halfword write
      wr(2, 32'hBEEF_0000, 4'hC, 4'h0);
      wr(2, 32'h0000_7E57, 4'h3, 4'h0);
      rd(2, 4'hF, "R3 half");
      idle(1);
      chk("R7 flag clean", DW'(err_flag), 0);

      // R4/R5 planted fault on lane 2
      wr(3, 32'hFFFF_0000, 4'hF, 4'h4);
      idle(1);
      chk("R10 no flag on write", DW'(err_flag), 0);
      rd(3, 4'hF, "R5 fault");
      idle(1);
      chk("R7 flag set", DW'(err_flag), 1);
      // R5 unread lane is not checked
      rd(3, 4'h3, "R5 lanes");
      // R6 checking disabled
      par_en = 0;
      rd(3, 4'hF, "R6 off");
      par_en = 1;
      idle(2);
      chk("R7 sticky", DW'(err_flag), 1);
      err_clr = 1; @(negedge clk); err_clr = 0;
      chk("R7 cleared", DW'(err_flag), 0);

      // R7 error and clear in the same cycle: set wins
      rd(3, 4'h4, "R7 race");
      err_clr = 1; @(negedge clk); err_clr = 0;
      chk("R7 set wins", DW'(err_flag), 1);
      err_clr = 1; @(negedge clk); err_clr = 0;

      // R8 break routing
      rd(3, 4'hF, "R8 unlocked");
      idle(1);
      lock_set = 1; @(negedge clk); lock_set = 0; exp_lock = 1;
      chk("R8 lock set", DW'(lock_q), 1);
      idle(3);
      chk("R8 lock held", DW'(lock_q), 1);
      rd(3, 4'hF, "R8 locked");
      rd(0, 4'hF, "R8 clean");
      // R4 rewriting the lane removes the fault
      wr(3, 32'h0055_0000, 4'h4, 4'h0);
      rd(3, 4'hF, "R4 repaired");
      // R4 fault in lane 0 of a fresh word, back-to-back reads
      wr(4, 32'h0000_0081, 4'hF, 4'h1);
      rd(4, 4'h1, "R4 lane0");
      rd(4, 4'hE, "R5 skip lane0");
      idle(2);
      chk("R9 nmi idle", DW'(nmi_req), 0);
      chk("R2 queue drained", DW'(q.size()), 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule